// File: doc/BRIEF.md
# Protected Interrupt Vector Relocation Register

This block is an 8-bit control register. It decides whether the interrupt vector table sits at the bottom of program memory or at the start of the boot section. The select bit can only be changed through a guarded two-step procedure. Software first sets a change-enable bit. Within the next four cycles it writes the new select value with change-enable written as zero. Any other attempt to change the select bit is dropped.

While that procedure is in progress, the block masks interrupt acceptance in hardware. It never touches the processor's global interrupt-enable flag. It also applies the boot-lock rules, which keep interrupts away from code running in a protected section whose vectors live elsewhere.

From the relocation state, the boot-size setting and the index of the pending interrupt, the block produces two values: the vector base and the word address to fetch the vector from. The five upper bits of the register are plain read/write enables, which are driven out to the interrupt sources.

Top module: `ivec_reloc_reg`

## Requirements
- R1: The register reads as {enables[7:3], 0 at bit 2, select at bit 1, change-enable at bit 0}. Every write stores bits 7:3 and drives them out on `ext_en`. Bit 2 always reads 0, and every bit is 0 after reset.
- R2: When select is 0, `vec_base` is 0. When select is 1, `vec_base` is the boot base taken from `boot_size`.
- R3: A write with bit 0 = 0 loads bit 1 into select only while change-enable reads 1. Such a write is accepted in any of the four cycles after the cycle that set change-enable. Outside that window, select keeps its value.
- R4: A write with bit 0 = 1 sets change-enable. Change-enable then reads 1 for exactly four cycles, unless an accepted select write clears it at once.
- R5: `irq_en` is 0 in three situations: during the cycle of a write that sets change-enable, while change-enable reads 1, and after an accepted select write. In the last case it stays 0 up to and including the first cycle after the write in which `insn_retire` is 1.
- R6: `irq_en` is 1 only when `glob_ie` is 1, no unlock masking is active and no lock condition holds.
- R7: The boot base is the word address 0x2000 - (0x400 >> `boot_size`). Codes 0, 1, 2 and 3 give 0x1C00, 0x1E00, 0x1F00 and 0x1F80. `vec_addr` is `vec_base` + 2 × `irq_idx`.
- R8: In two cases the lock condition holds and forces `irq_en` to 0. The first is select = 1 with `lock_app` = 1 and `exec_in_boot` = 0. The second is select = 0 with `lock_boot` = 1 and `exec_in_boot` = 1.
- R9: A write with bit 0 = 1 while change-enable is already 1 restarts the four-cycle count from that write.
- R10: A write with bits 1 and 0 both 1 sets change-enable and leaves select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| insn_retire | input | 1 | Pulses when an instruction completes |
| boot_size | input | 2 | Boot section size code |
| lock_app | input | 1 | Application-section protection lock |
| lock_boot | input | 1 | Boot-section protection lock |
| exec_in_boot | input | 1 | Code currently executes from the boot section |
| glob_ie | input | 1 | Global interrupt enable from the status register |
| irq_idx | input | IDX_W | Index of the pending interrupt |
| ext_en | output | 5 | Stored external interrupt enables |
| vec_base | output | ADDR_W | Vector table base word address |
| vec_addr | output | ADDR_W | Vector fetch word address |
| irq_en | output | 1 | Gated interrupt acceptance enable |

## Verification
The assertions assume that `rst_n` is asserted before the first clock edge. They also assume that `reg_wr`, `reg_wdata` and `insn_retire` change only away from the active edge, so a write seen at an edge is the same write the masking logic saw during that cycle. The stimulus drives every input just after the falling edge and applies the reset at time zero. The lock and index inputs are only swept while no unlock window or post-write hold is open, so each lock or address check sees a single cause.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  // Bit positions are fixed: software decodes them.
  localparam int IVR_CE_BIT   = 0;
  localparam int IVR_SEL_BIT  = 1;
  localparam int IVR_RSVD_BIT = 2;
  localparam int IVR_EXT_LSB  = 3;
  localparam int IVR_EXT_W    = 5;

  typedef struct packed {
    logic [IVR_EXT_W-1:0] ext;
    logic                 rsvd;
    logic                 sel;
    logic                 ce;
  } ivr_reg_t;
endpackage

// File: rtl/ivr_unlock.sv
module ivr_unlock #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_ce,
  input  logic wr_sel,
  input  logic insn_retire,
  output logic vsel,
  output logic chg_en,
  output logic unlock_mask,
  output logic ce_set,
  output logic sel_wr_ok
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] win_cnt;
  logic             post_hold;

  assign ce_set    = wr & wr_ce;
  assign sel_wr_ok = wr & ~wr_ce & chg_en;
  assign chg_en    = (win_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (ce_set) begin
      win_cnt <= CNT_LOAD;
    end else if (sel_wr_ok) begin
      win_cnt <= '0;
    end else if (chg_en) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsel <= 1'b0;
    end else if (sel_wr_ok) begin
      vsel <= wr_sel;
    end
  end

  // Hold the mask past the select write until the next instruction ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_hold <= 1'b0;
    end else if (sel_wr_ok) begin
      post_hold <= 1'b1;
    end else if (post_hold && insn_retire) begin
      post_hold <= 1'b0;
    end
  end

  assign unlock_mask = ce_set | chg_en | post_hold;

  AST_SEL_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsel) |-> ($past(chg_en) && $past(wr) && !$past(wr_ce))); // R3
  AST_CE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_en) |-> ($past(wr) && $past(wr_ce))); // R4
  AST_CE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt == CNT_W'(1) && !wr) |=> !chg_en); // R4
  AST_CE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ce_set |=> (win_cnt == CNT_LOAD)); // R9
  AST_HOLD_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_ok |=> unlock_mask); // R5
  AST_BOTH_BITS_KEEP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_ce && wr_sel) |=> $stable(vsel)); // R10
endmodule

// File: rtl/ivr_vec_map.sv
module ivr_vec_map #(
  parameter int ADDR_W         = 16,
  parameter int IDX_W          = 5,
  parameter int FLASH_WORDS    = 8192,
  parameter int MAX_BOOT_WORDS = 1024
) (
  input  logic              vsel,
  input  logic [1:0]        boot_size,
  input  logic [IDX_W-1:0]  irq_idx,
  output logic [ADDR_W-1:0] vec_base,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int ENTRY_WORDS = 2;

  function automatic logic [ADDR_W-1:0] boot_base_f(input logic [1:0] code);
    int words;
    words = MAX_BOOT_WORDS >> code;
    return ADDR_W'(FLASH_WORDS - words);
  endfunction

  function automatic logic [ADDR_W-1:0] entry_addr_f(input logic [ADDR_W-1:0] base,
                                                     input logic [IDX_W-1:0]  idx);
    return base + ADDR_W'(ENTRY_WORDS * int'(idx));
  endfunction

  assign vec_base = vsel ? boot_base_f(boot_size) : '0;
  assign vec_addr = entry_addr_f(vec_base, irq_idx);
endmodule

// File: rtl/ivr_irq_gate.sv
module ivr_irq_gate (
  input  logic glob_ie,
  input  logic unlock_mask,
  input  logic vsel,
  input  logic lock_app,
  input  logic lock_boot,
  input  logic exec_in_boot,
  output logic lock_block,
  output logic irq_en
);
  // Vectors in boot but running protected application code, or the reverse.
  assign lock_block = (vsel & lock_app & ~exec_in_boot) |
                      (~vsel & lock_boot & exec_in_boot);
  assign irq_en     = glob_ie & ~unlock_mask & ~lock_block;
endmodule

// File: rtl/ivec_reloc_reg.sv
module ivec_reloc_reg
  import ivr_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int IDX_W          = 5,
  parameter int FLASH_WORDS    = 8192,
  parameter int MAX_BOOT_WORDS = 1024,
  parameter int WIN_CYC        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              insn_retire,
  input  logic [1:0]        boot_size,
  input  logic              lock_app,
  input  logic              lock_boot,
  input  logic              exec_in_boot,
  input  logic              glob_ie,
  input  logic [IDX_W-1:0]  irq_idx,
  output logic [4:0]        ext_en,
  output logic [ADDR_W-1:0] vec_base,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              irq_en
);
  ivr_reg_t wfield;
  ivr_reg_t rfield;
  logic     vsel, chg_en, unlock_mask, ce_set, sel_wr_ok, lock_block;
  logic [IVR_EXT_W-1:0] ext_q;
  logic     rsvd_unused;

  assign wfield      = ivr_reg_t'(reg_wdata);
  assign rsvd_unused = wfield.rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
    end else if (reg_wr) begin
      ext_q <= wfield.ext;
    end
  end

  ivr_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (reg_wr),
    .wr_ce       (wfield.ce),
    .wr_sel      (wfield.sel),
    .insn_retire (insn_retire),
    .vsel        (vsel),
    .chg_en      (chg_en),
    .unlock_mask (unlock_mask),
    .ce_set      (ce_set),
    .sel_wr_ok   (sel_wr_ok)
  );

  ivr_vec_map #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .FLASH_WORDS(FLASH_WORDS), .MAX_BOOT_WORDS(MAX_BOOT_WORDS)
  ) u_map (
    .vsel      (vsel),
    .boot_size (boot_size),
    .irq_idx   (irq_idx),
    .vec_base  (vec_base),
    .vec_addr  (vec_addr)
  );

  ivr_irq_gate u_gate (
    .glob_ie      (glob_ie),
    .unlock_mask  (unlock_mask),
    .vsel         (vsel),
    .lock_app     (lock_app),
    .lock_boot    (lock_boot),
    .exec_in_boot (exec_in_boot),
    .lock_block   (lock_block),
    .irq_en       (irq_en)
  );

  always_comb begin
    rfield      = '0;
    rfield.ext  = ext_q;
    rfield.sel  = vsel;
    rfield.ce   = chg_en;
  end
  assign reg_rdata = rfield;
  assign ext_en    = ext_q;

  AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[IVR_RSVD_BIT] == 1'b0); // R1
  AST_APP_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vsel |-> (vec_base == '0)); // R2
  AST_ENTRY_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_addr - vec_base) == ADDR_W'(2 * int'(irq_idx))); // R7
  AST_MASK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en || ce_set) |-> !irq_en); // R5
  AST_GATE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |-> glob_ie); // R6
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_block |-> !irq_en); // R8
  AST_SEL_EVENT_CLEARS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_ok |=> !chg_en); // R4
endmodule

// File: tb/tb_ivec_reloc_reg.sv
module tb_ivec_reloc_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        insn_retire = 1'b0;
  logic [1:0]  boot_size = '0;
  logic        lock_app = 1'b0, lock_boot = 1'b0, exec_in_boot = 1'b0;
  logic        glob_ie = 1'b1;
  logic [4:0]  irq_idx = '0;
  logic [4:0]  ext_en;
  logic [15:0] vec_base, vec_addr;
  logic        irq_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ivec_reloc_reg dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .insn_retire(insn_retire), .boot_size(boot_size),
    .lock_app(lock_app), .lock_boot(lock_boot), .exec_in_boot(exec_in_boot),
    .glob_ie(glob_ie), .irq_idx(irq_idx), .ext_en(ext_en),
    .vec_base(vec_base), .vec_addr(vec_addr), .irq_en(irq_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply one cycle of inputs after the falling edge; comb outputs settle at #1.
  task automatic cyc(input logic wr, input logic [7:0] d, input logic ret);
    @(negedge clk);
    reg_wr = wr; reg_wdata = d; insn_retire = ret;
    #1;
  endtask

  task automatic set_sel(input logic s);
    cyc(1'b1, 8'h01, 1'b0);
    cyc(1'b1, {6'b0, s, 1'b0}, 1'b0);
    cyc(1'b0, 8'h00, 1'b1);
    cyc(1'b0, 8'h00, 1'b0);
  endtask

  function automatic int exp_base(input int s, input int bs);
    return (s != 0) ? (8192 - (1024 >> bs)) : 0;
  endfunction

  function automatic int exp_lock(input int s, input int la, input int lb, input int eb);
    return ((s != 0 && la != 0 && eb == 0) || (s == 0 && lb != 0 && eb != 0)) ? 1 : 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev_sel;
    int   ce_cycles;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 reset rdata", reg_rdata, 0);
    check("R2 reset base", vec_base, 0);
    check("R6 reset irq_en", irq_en, 1);

    // R1 enable bits sweep, bit 2 written as 1, select write ignored (R3)
    for (int v = 0; v < 32; v++) begin
      cyc(1'b1, {v[4:0], 3'b110}, 1'b0);
      cyc(1'b0, 8'h00, 1'b0);
      check("R1 readback", reg_rdata, v << 3);
      check("R1 ext_en", ext_en, v);
    end
    cyc(1'b1, 8'h00, 1'b0);
    cyc(1'b0, 8'h00, 1'b0);

    // R3 window sweep: select written d idle cycles after change-enable
    prev_sel = 1'b0;
    for (int d = 0; d < 7; d++) begin
      logic tgt;
      tgt = ~prev_sel;
      cyc(1'b1, 8'h01, 1'b0);
      repeat (d) cyc(1'b0, 8'h00, 1'b0);
      cyc(1'b1, {6'b0, tgt, 1'b0}, 1'b0);
      cyc(1'b0, 8'h00, 1'b1);
      if (d <= 3) prev_sel = tgt;
      check("R3 select after window write", reg_rdata[1], prev_sel);
      check("R4 change-enable cleared", reg_rdata[0], 0);
      cyc(1'b0, 8'h00, 1'b0);
    end
    set_sel(1'b0);

    // R4/R5 change-enable lifetime and masking without select write
    cyc(1'b1, 8'h01, 1'b0);
    check("R5 mask in set cycle", irq_en, 0);
    ce_cycles = 0;
    for (int k = 1; k <= 6; k++) begin
      cyc(1'b0, 8'h00, 1'b0);
      ce_cycles += reg_rdata[0];
      check("R5 mask tracks window", irq_en, (k <= 4) ? 0 : 1);
    end
    check("R4 change-enable lifetime", ce_cycles, 4);

    // R4 early clear and R5 hold until next retire
    cyc(1'b1, 8'h01, 1'b0);
    cyc(1'b1, 8'h02, 1'b0);
    check("R5 mask in select write cycle", irq_en, 0);
    cyc(1'b0, 8'h00, 1'b0);
    check("R4 early clear", reg_rdata[0], 0);
    check("R3 select accepted", reg_rdata[1], 1);
    check("R5 hold before retire", irq_en, 0);
    cyc(1'b0, 8'h00, 1'b0);
    check("R5 hold before retire", irq_en, 0);
    cyc(1'b0, 8'h00, 1'b1);
    check("R5 hold in retire cycle", irq_en, 0);
    cyc(1'b0, 8'h00, 1'b0);
    check("R5 released after retire", irq_en, 1);
    set_sel(1'b0);

    // R9 restart of the window
    cyc(1'b1, 8'h01, 1'b0);
    cyc(1'b0, 8'h00, 1'b0);
    cyc(1'b0, 8'h00, 1'b0);
    cyc(1'b1, 8'h01, 1'b0);
    ce_cycles = 0;
    for (int k = 1; k <= 6; k++) begin
      cyc(1'b0, 8'h00, 1'b0);
      ce_cycles += reg_rdata[0];
    end
    check("R9 restarted lifetime", ce_cycles, 4);

    // R10 both bits set together
    cyc(1'b1, 8'h03, 1'b0);
    cyc(1'b0, 8'h00, 1'b0);
    check("R10 change-enable set", reg_rdata[0], 1);
    check("R10 select unchanged", reg_rdata[1], 0);
    repeat (5) cyc(1'b0, 8'h00, 1'b0);

    // R2/R7 address sweep
    for (int s = 0; s < 2; s++) begin
      set_sel(s[0]);
      for (int bs = 0; bs < 4; bs++) begin
        for (int ix = 0; ix < 32; ix++) begin
          @(negedge clk);
          boot_size = bs[1:0]; irq_idx = ix[4:0];
          #1;
          check("R2 vec_base", vec_base, exp_base(s, bs));
          check("R7 vec_addr", vec_addr, exp_base(s, bs) + 2 * ix);
        end
      end
    end

    // R8/R6 lock and global enable sweep
    for (int s = 0; s < 2; s++) begin
      set_sel(s[0]);
      for (int g = 0; g < 2; g++) begin
        for (int c = 0; c < 8; c++) begin
          @(negedge clk);
          glob_ie = g[0]; lock_app = c[0]; lock_boot = c[1]; exec_in_boot = c[2];
          #1;
          check(g != 0 ? "R8 lock gating" : "R6 global enable",
                irq_en, (g != 0 && exp_lock(s, c & 1, (c >> 1) & 1, (c >> 2) & 1) == 0) ? 1 : 0);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule